// File: doc/BRIEF.md
# Serial Port Control and Interrupt Request Unit

This block holds the control byte and the status flags of an asynchronous or clocked serial port, and turns them into three level interrupt requests: transmit buffer empty, receive buffer full and receive error. A processor reaches it through a simple byte-wide read/write bus with two addresses. The serial datapath reports events as single-cycle set pulses. One pulse marks a byte moving from the transmit buffer into the shifter. Another marks a byte landing in the receive buffer. Three more mark framing, parity and overrun errors.

A status flag cannot be cleared by a blind write. The processor must first read the status register while the flag is 1. Only a later write of 0 to that bit clears it. A write of 1 never sets a flag. The receive interrupt enable gates both the receive-full request and the error request. The transmitter enable, receiver enable and clock-source bits leave the block directly as control outputs. The multiprocessor and transmit-end enable bits are only stored and read back.

Top module: `sercom_ctl_irq`

## Requirements
- R1: After reset the control register (address 0) reads 0x00. The status register (address 1) reads 0x01. All interrupt outputs are 0. Status bit positions: bit0 transmit-empty, bit1 receive-full, bit2 framing error, bit3 parity error, bit4 overrun error, bits 7..5 read 0.
- R2: The control register is read/write at all times, with this layout from bit 7 down to bit 0: transmit irq enable, receive irq enable, transmit enable, receive enable, multiprocessor irq enable, transmit-end irq enable, clock select 1, clock select 0. Bit 5 drives `tx_en_o`, bit 4 drives `rx_en_o`, and bits 1..0 drive `clk_src_o`.
- R3: While `standby_i` is high, the control register returns to 0x00 at the next clock edge. The status flags are unaffected.
- R4: A `tx_moved_i` pulse sets transmit-empty. `irq_tx_empty_o` equals transmit-empty AND control bit 7.
- R5: An `rx_filled_i` pulse sets receive-full. `irq_rx_full_o` equals receive-full AND control bit 6.
- R6: Pulses on `err_frame_i`, `err_parity_i` and `err_overrun_i` set their error flags. `irq_rx_err_o` equals the OR of the three error flags AND control bit 6.
- R7: A status flag is cleared only by a status write of 0 in its bit position. That write must follow a status read that returned 1 in that bit. A write of 0 with no such read leaves the flag at 1. A read that returned 0 does not enable a later clear.
- R8: Writing 1 to a status bit never sets the flag.
- R9: When a set pulse and a valid clear for the same flag arrive in the same cycle, the flag stays 1.
- R10: Clearing an interrupt enable bit drops the matching requests in the cycle the new control value is registered. The flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby_i | input | 1 | Standby request, clears the control register |
| addr_i | input | ADDR_W | Register address: 0 control, 1 status |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (status reads arm flag clears) |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for the addressed register |
| tx_moved_i | input | 1 | Set pulse for transmit-empty |
| rx_filled_i | input | 1 | Set pulse for receive-full |
| err_frame_i | input | 1 | Set pulse for framing error |
| err_parity_i | input | 1 | Set pulse for parity error |
| err_overrun_i | input | 1 | Set pulse for overrun error |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| clk_src_o | output | 2 | Clock-source select bits |
| irq_tx_empty_o | output | 1 | Transmit-empty interrupt request |
| irq_rx_full_o | output | 1 | Receive-full interrupt request |
| irq_rx_err_o | output | 1 | Receive-error interrupt request |

## Verification
The assertions check, on every cycle, the following. A flag never falls unless it was armed by an earlier read. A flag never rises without a set pulse. A set pulse always leaves its flag at 1. Standby empties the control byte. No request is raised while its enable or flag is low. The scenarios show what a property cannot see on its own: the complete read-then-write-0 sequence that clears each flag, a read that saw 0 failing to arm a clear, the exact control and status values read back over the bus, and requests coming back when an enable is set again.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
   // Control byte, most significant field first; bit positions are fixed.
   typedef struct packed {
      logic       tx_irq_en;   // 7
      logic       rx_irq_en;   // 6
      logic       tx_en;       // 5
      logic       rx_en;       // 4
      logic       mp_irq_en;   // 3
      logic       tend_irq_en; // 2
      logic [1:0] clk_sel;     // 1..0
   } ctrl_t;

   localparam int unsigned NUM_FLAGS = 5;
   localparam int unsigned FLG_TXE   = 0;
   localparam int unsigned FLG_RXF   = 1;
   localparam int unsigned FLG_FER   = 2;
   localparam int unsigned FLG_PER   = 3;
   localparam int unsigned FLG_OVR   = 4;
   localparam logic [NUM_FLAGS-1:0] FLAG_RST = 5'b00001;
endpackage

// File: rtl/sercom_ctrl_reg.sv
module sercom_ctrl_reg
   import sercom_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  standby_i,
   input  logic  wr_i,
   input  ctrl_t wdata_i,
   output ctrl_t ctrl_o
);
   ctrl_t ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (standby_i)
         ctrl_q <= '0;
      else if (wr_i)
         ctrl_q <= wdata_i;
   end

   assign ctrl_o = ctrl_q;
endmodule

// File: rtl/sercom_flag_cell.sv
module sercom_flag_cell #(
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic flag_o,
   output logic arm_o
);
   logic flag_q, arm_q, clr_ok;

   // A zero written while armed is a legal clear.
   assign clr_ok = wr_i & ~wbit_i & arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= RESET_VAL;
         arm_q  <= 1'b0;
      end else begin
         if (set_i)
            flag_q <= 1'b1;
         else if (clr_ok)
            flag_q <= 1'b0;

         if (clr_ok)
            arm_q <= 1'b0;
         else if (rd_i && flag_q)
            arm_q <= 1'b1;
      end
   end

   assign flag_o = flag_q;
   assign arm_o  = arm_q;
endmodule

// File: rtl/sercom_irq_gen.sv
module sercom_irq_gen #(
   parameter int unsigned NFLAG = 5
) (
   input  logic             tx_irq_en_i,
   input  logic             rx_irq_en_i,
   input  logic [NFLAG-1:0] flags_i,
   output logic             irq_tx_o,
   output logic             irq_rx_o,
   output logic             irq_err_o
);
   localparam int unsigned ERR_LO = 2;

   logic any_err;

   assign any_err   = |flags_i[NFLAG-1:ERR_LO];
   assign irq_tx_o  = flags_i[0] & tx_irq_en_i;
   assign irq_rx_o  = flags_i[1] & rx_irq_en_i;
   assign irq_err_o = any_err & rx_irq_en_i;
endmodule

// File: rtl/sercom_ctl_irq.sv
module sercom_ctl_irq
   import sercom_pkg::*;
#(
   parameter int unsigned ADDR_W    = 1,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CTRL_ADDR = 0,
   parameter int unsigned STAT_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              tx_moved_i,
   input  logic              rx_filled_i,
   input  logic              err_frame_i,
   input  logic              err_parity_i,
   input  logic              err_overrun_i,
   output logic              tx_en_o,
   output logic              rx_en_o,
   output logic [1:0]        clk_src_o,
   output logic              irq_tx_empty_o,
   output logic              irq_rx_full_o,
   output logic              irq_rx_err_o
);
   localparam int unsigned PAD_W = DATA_W - NUM_FLAGS;

   if (DATA_W != $bits(ctrl_t)) begin : g_bad_width
      $error("sercom_ctl_irq: DATA_W must equal the control byte width");
   end
   if (CTRL_ADDR == STAT_ADDR) begin : g_bad_addr
      $error("sercom_ctl_irq: register addresses must differ");
   end
   if (STAT_ADDR >= (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_range
      $error("sercom_ctl_irq: address outside ADDR_W range");
   end

   logic                 ctrl_sel, stat_sel;
   logic                 ctrl_wr, stat_wr, stat_rd;
   ctrl_t                ctrl_q;
   logic [NUM_FLAGS-1:0] set_vec, flags_q, arm_q;

   assign ctrl_sel = (addr_i == ADDR_W'(CTRL_ADDR));
   assign stat_sel = (addr_i == ADDR_W'(STAT_ADDR));
   assign ctrl_wr  = wr_i & ctrl_sel;
   assign stat_wr  = wr_i & stat_sel;
   assign stat_rd  = rd_i & stat_sel & ~wr_i;

   sercom_ctrl_reg u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .standby_i (standby_i),
      .wr_i      (ctrl_wr),
      .wdata_i   (ctrl_t'(wdata_i)),
      .ctrl_o    (ctrl_q)
   );

   assign set_vec = {err_overrun_i, err_parity_i, err_frame_i, rx_filled_i, tx_moved_i};

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      sercom_flag_cell #(.RESET_VAL(FLAG_RST[i])) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_vec[i]),
         .rd_i   (stat_rd),
         .wr_i   (stat_wr),
         .wbit_i (wdata_i[i]),
         .flag_o (flags_q[i]),
         .arm_o  (arm_q[i])
      );
   end

   sercom_irq_gen #(.NFLAG(NUM_FLAGS)) u_irq (
      .tx_irq_en_i (ctrl_q.tx_irq_en),
      .rx_irq_en_i (ctrl_q.rx_irq_en),
      .flags_i     (flags_q),
      .irq_tx_o    (irq_tx_empty_o),
      .irq_rx_o    (irq_rx_full_o),
      .irq_err_o   (irq_rx_err_o)
   );

   always_comb begin
      if (ctrl_sel)
         rdata_o = ctrl_q;
      else if (stat_sel)
         rdata_o = {{PAD_W{1'b0}}, flags_q};
      else
         rdata_o = '0;
   end

   assign tx_en_o   = ctrl_q.tx_en;
   assign rx_en_o   = ctrl_q.rx_en;
   assign clk_src_o = ctrl_q.clk_sel;
endmodule

// File: rtl/sercom_ctl_irq_chk.sv
module sercom_ctl_irq_chk #(
   parameter int unsigned NF = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          standby_i,
   input logic          ctrl_wr,
   input logic [7:0]    ctrl_q,
   input logic [NF-1:0] set_vec,
   input logic [NF-1:0] flags_q,
   input logic [NF-1:0] arm_q,
   input logic          irq_tx_empty_o,
   input logic          irq_rx_full_o,
   input logic          irq_rx_err_o
);
   // Control only changes through a write or standby (R2)
   assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ctrl_wr) && !$past(standby_i)) |-> $stable(ctrl_q));

   assert_standby_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      standby_i |=> (ctrl_q == 8'h00));

   assert_tx_req_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx_empty_o |-> (flags_q[0] && ctrl_q[7]));

   assert_rx_req_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx_full_o |-> flags_q[1]);

   assert_err_req_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx_err_o |-> (|flags_q[NF-1:2]));

   assert_no_unarmed_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((~flags_q & $past(flags_q) & ~$past(arm_q)) == '0));

   assert_no_spurious_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags_q & ~$past(flags_q) & ~$past(set_vec)) == '0));

   assert_set_dominates_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

   assert_rx_enable_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[6] |-> (!irq_rx_full_o && !irq_rx_err_o));
endmodule

bind sercom_ctl_irq sercom_ctl_irq_chk #(.NF(sercom_pkg::NUM_FLAGS)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .standby_i      (standby_i),
   .ctrl_wr        (ctrl_wr),
   .ctrl_q         (ctrl_q),
   .set_vec        (set_vec),
   .flags_q        (flags_q),
   .arm_q          (arm_q),
   .irq_tx_empty_o (irq_tx_empty_o),
   .irq_rx_full_o  (irq_rx_full_o),
   .irq_rx_err_o   (irq_rx_err_o)
);

// File: tb/test_sercom_ctl_irq.sv
`timescale 1ns/1ps
module test_sercom_ctl_irq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       standby = 1'b0;
   logic [0:0] addr = '0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [4:0] pulse = '0;
   logic       tx_en, rx_en, irq_tx, irq_rx, irq_err;
   logic [1:0] clk_src;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sercom_ctl_irq i_sercom_ctl_irq (
      .clk            (clk),
      .rst_n          (rst_n),
      .standby_i      (standby),
      .addr_i         (addr),
      .wr_i           (wr),
      .rd_i           (rd),
      .wdata_i        (wdata),
      .rdata_o        (rdata),
      .tx_moved_i     (pulse[0]),
      .rx_filled_i    (pulse[1]),
      .err_frame_i    (pulse[2]),
      .err_parity_i   (pulse[3]),
      .err_overrun_i  (pulse[4]),
      .tx_en_o        (tx_en),
      .rx_en_o        (rx_en),
      .clk_src_o      (clk_src),
      .irq_tx_empty_o (irq_tx),
      .irq_rx_full_o  (irq_rx),
      .irq_rx_err_o   (irq_err)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic bus_rd(input logic a, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic fire(input logic [4:0] v);
      @(negedge clk); pulse = v;
      @(negedge clk); pulse = '0;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      bus_rd(0, d); check("R1 ctrl", d, 8'h00);
      bus_rd(1, d); check("R1 status", d, 8'h01);
      check("R1 irqs", {5'b0, irq_tx, irq_rx, irq_err}, 8'h00);
   endtask

   task automatic t_ctrl;
      logic [7:0] d;
      bus_wr(0, 8'hA5); bus_rd(0, d); check("R2 readback A5", d, 8'hA5);
      check("R2 outs A5", {4'b0, tx_en, rx_en, clk_src}, 8'h09);
      bus_wr(0, 8'h5A); bus_rd(0, d); check("R2 readback 5A", d, 8'h5A);
      check("R2 outs 5A", {4'b0, tx_en, rx_en, clk_src}, 8'h06);
   endtask

   task automatic t_standby;
      logic [7:0] d;
      @(negedge clk); standby = 1'b1;
      @(negedge clk); standby = 1'b0;
      bus_rd(0, d); check("R3 ctrl cleared", d, 8'h00);
      bus_rd(1, d); check("R3 status kept", d, 8'h01);
   endtask

   task automatic t_tx;
      logic [7:0] d;
      bus_wr(0, 8'h80); check("R4 irq on", {7'b0, irq_tx}, 8'h01);
      bus_wr(0, 8'h00); check("R10 irq off", {7'b0, irq_tx}, 8'h00);
      bus_rd(1, d); check("R10 flag kept", d, 8'h01);
      bus_wr(0, 8'h80);
      // the read above armed bit0; rearm-free blind write first needs a fresh state
      bus_wr(1, 8'hFE); bus_rd(1, d); check("R7 armed clear", d, 8'h00);
      check("R4 irq drops", {7'b0, irq_tx}, 8'h00);
      fire(5'b00001); check("R4 irq after set", {7'b0, irq_tx}, 8'h01);
      bus_wr(1, 8'h00); bus_rd(1, d); check("R7 blind write", d, 8'h01);
   endtask

   task automatic t_rx;
      logic [7:0] d;
      bus_wr(0, 8'h40); check("R5 idle", {7'b0, irq_rx}, 8'h00);
      fire(5'b00010); check("R5 irq on", {7'b0, irq_rx}, 8'h01);
      bus_wr(1, 8'hFD); bus_rd(1, d); check("R7 blind rx", d, 8'h03);
      bus_wr(1, 8'hFD); bus_rd(1, d); check("R7 rx cleared", d, 8'h01);
      check("R5 irq off", {7'b0, irq_rx}, 8'h00);
      // last read saw rx at 0: that must not arm it
      fire(5'b00010); bus_wr(1, 8'hFD); bus_rd(1, d);
      check("R7 zero read no arm", d, 8'h03);
      bus_wr(1, 8'hFD); bus_rd(1, d); check("R7 rx cleared again", d, 8'h01);
   endtask

   task automatic t_write_one;
      logic [7:0] d;
      bus_wr(1, 8'hFF); bus_rd(1, d); check("R8 write ones", d, 8'h01);
   endtask

   task automatic t_err;
      logic [7:0] d;
      for (int i = 2; i < 5; i++) begin
         fire(5'(1 << i));
         check("R6 err irq", {7'b0, irq_err}, 8'h01);
         bus_wr(0, 8'h00);
         check("R10 err gated", {6'b0, irq_rx, irq_err}, 8'h00);
         bus_wr(0, 8'h40);
         bus_rd(1, d); check("R6 err flag", d, 8'h01 | 8'(1 << i));
         bus_wr(1, ~8'(1 << i)); bus_rd(1, d); check("R7 err cleared", d, 8'h01);
         check("R6 err irq off", {7'b0, irq_err}, 8'h00);
      end
   endtask

   task automatic t_set_wins;
      logic [7:0] d;
      fire(5'b00010); bus_rd(1, d);
      @(negedge clk); addr = 1'b1; wdata = 8'hFD; wr = 1'b1; pulse = 5'b00010;
      @(negedge clk); wr = 1'b0; pulse = '0;
      bus_rd(1, d); check("R9 set wins", d, 8'h03);
      bus_wr(1, 8'hFD); bus_rd(1, d); check("R9 later clear", d, 8'h01);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl();
      t_standby();
      t_tx();
      t_rx();
      t_write_one();
      t_err();
      t_set_wins();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule